// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block is the register-mapped power controller for a small group of power domains inside a graphics accelerator. Software writes a bitmask to a power-up command register or a power-down command register. The controller then switches the selected domains one at a time, lowest bit first.

For each domain it moves the domain's enable output and waits until that domain's acknowledge input matches. It then counts a software-programmed switch delay before it treats the step as done.

The status register shows one bit per domain, with a set bit meaning the domain is powered down. The end of each command is reported through a raw completion flag. An interrupt mask gates that flag onto the interrupt line, and a write-one-to-clear register clears it. A legacy-mode input suppresses the completion flag when a power-down leaves every implemented domain off.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset every implemented domain reads as powered down (status bit = 1), status bits at and above N_DOM read 0, all enables are low, and the interrupt mask, raw flag, switch delay and irq are all 0.
- R2: A write to the power-up command register (offset 0x00) raises the enable of every selected domain that is off; each of those status bits reads 0 once the command completes.
- R3: A write to the power-down command register (offset 0x04) lowers the enable of every selected domain that is on; each of those status bits reads 1 once the command completes.
- R4: Command bits for domains already in the requested state, and bits at or above N_DOM, are ignored. A command with an empty effective mask completes at once and sets the completion flag, except in the legacy all-off case of R11.
- R5: Selected domains are switched one at a time in ascending bit order, and at most one enable output changes in any cycle.
- R6: A domain step changes its enable, waits for its acknowledge to equal the enable, and then waits the switch-delay value (offset 0x1C) in cycles before it commits. The status bit changes only at the commit. The interval between two consecutive enable changes is the delay value plus 4 cycles when the acknowledge follows the enable one cycle later.
- R7: The end of a command sets the raw completion flag (offset 0x10, bit 0) whatever the interrupt mask holds.
- R8: Writing a value with bit 0 set to the clear register (offset 0x18) clears the raw flag. Writing 0 there leaves the flag unchanged.
- R9: irq is high exactly when both the raw flag and the interrupt mask bit (offset 0x0C, bit 0) are 1.
- R10: A write to either command register while a command is in progress is ignored: it causes no enable change and no status change.
- R11: With legacy_mode high, a power-down command that leaves every implemented domain off does not set the completion flag. With legacy_mode low, such a command does set it.
- R12: Reads of the command registers and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (combinational on reg_addr) |
| legacy_mode | input | 1 | Suppress completion flag when a power-down leaves all domains off |
| dom_pwr_en | output | N_DOM | Per-domain power enable |
| dom_pwr_ack | input | N_DOM | Per-domain power acknowledge |
| irq | output | 1 | Masked completion interrupt |

## Verification
A wrong step pointer or pending mask in the sequencer shows at the enable outputs within one step. It appears as an enable that toggles out of ascending order or toggles twice, and it is visible the cycle after the bad pick.

A wrong delay count shows as a changed spacing between consecutive enable edges. A wrong commit shows as a status read that disagrees once the flag arrives.

A completion flag that is lost or suppressed by mistake shows as a poll timeout of a few hundred cycles. A flag that is raised by mistake shows on the first raw-status read after the command.

// File: rtl/pwr_seq_pkg.sv
// Shared definitions for the power domain sequencing controller.
// Assumes byte offsets on a 5-bit register address.
package pwr_seq_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_UP   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DN   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_IMSK = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_RAW  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_DLY  = 5'h1C;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SCAN, ST_ACK, ST_DLY, ST_DONE
    } seq_state_t;
endpackage

// File: rtl/pwr_seq_timer.sv
// Switch-delay down-counter. A load starts a count of load_val cycles;
// expired is high while the count sits at zero and the timer is running.
// Assumes load is never asserted while expired is high.
module pwr_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;
    logic             run;

    // Load, count down, and stop once expiry has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= load_val;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

    // R6: a load arms the timer with exactly the programmed delay
    a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (run && cnt == $past(load_val)));
endmodule

// File: rtl/pwr_seq_engine.sv
// Domain sequencer. Latches the effective mask of a command, then steps
// through its set bits in ascending order: drive the enable, wait for the
// acknowledge to match, wait the switch delay, commit. Commands are
// accepted only in IDLE. Assumes at most one command strobe per cycle.
module pwr_seq_engine
    import pwr_seq_pkg::*;
#(
    parameter int N_DOM = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_wr,
    input  logic             dn_wr,
    input  logic [N_DOM-1:0] wmask,
    input  logic             legacy,
    input  logic [N_DOM-1:0] dom_ack,
    input  logic             tmr_exp,
    output logic             tmr_load,
    output logic [N_DOM-1:0] dom_en,
    output logic [N_DOM-1:0] dom_on,
    output logic             cmd_done
);
    localparam int IDX_W = (N_DOM > 1) ? $clog2(N_DOM) : 1;

    seq_state_t       state;
    logic [N_DOM-1:0] pend;
    logic             dir_up;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] low_idx;
    logic             ack_ok;

    // Find the lowest pending domain.
    always_comb begin
        low_idx = '0;
        for (int i = N_DOM - 1; i >= 0; i--) begin
            if (pend[i]) low_idx = IDX_W'(i);
        end
    end

    assign ack_ok   = (dom_ack[idx] == dom_en[idx]);
    assign tmr_load = (state == ST_ACK) && ack_ok;
    assign cmd_done = (state == ST_DONE) && !(legacy && !dir_up && dom_on == '0);

    // Command acceptance and per-domain step sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend   <= '0;
            dir_up <= 1'b0;
            idx    <= '0;
            dom_en <= '0;
            dom_on <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (up_wr) begin
                        pend   <= wmask & ~dom_on;
                        dir_up <= 1'b1;
                        state  <= ST_SCAN;
                    end else if (dn_wr) begin
                        pend   <= wmask & dom_on;
                        dir_up <= 1'b0;
                        state  <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (pend == '0) begin
                        state <= ST_DONE;
                    end else begin
                        idx             <= low_idx;
                        dom_en[low_idx] <= dir_up;
                        state           <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (ack_ok) state <= ST_DLY;
                end
                ST_DLY: begin
                    if (tmr_exp) begin
                        dom_on[idx] <= dir_up;
                        pend[idx]   <= 1'b0;
                        state       <= ST_SCAN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: never more than one enable edge per cycle
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dom_en ^ $past(dom_en)) <= 1);
    // R6: a domain's committed state changes only after the delay expired
    a_r6_commit_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_on != $past(dom_on)) |-> $past(tmr_exp));
    // R4: completion is signalled only with nothing left pending
    a_r4_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (pend == '0));
endmodule

// File: rtl/pwr_seq_regs.sv
// Register port: decodes command strobes, holds the interrupt mask, the
// raw completion flag and the switch delay, and muxes read data.
// Assumes reads are combinational on the address.
module pwr_seq_regs
    import pwr_seq_pkg::*;
#(
    parameter int N_DOM  = 4,
    parameter int DLY_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_DOM-1:0]  dom_on,
    input  logic              cmd_done,
    output logic              up_wr,
    output logic              dn_wr,
    output logic [N_DOM-1:0]  wmask,
    output logic [DLY_W-1:0]  dly_val,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic imsk;
    logic raw;
    logic clr_hit;
    logic unused_hi;

    assign up_wr     = wr_en && (addr == OFS_UP);
    assign dn_wr     = wr_en && (addr == OFS_DN);
    assign wmask     = wdata[N_DOM-1:0];
    assign clr_hit   = wr_en && (addr == OFS_CLR) && wdata[0];
    assign unused_hi = ^wdata[DATA_W-1:DLY_W];

    // Mask and delay register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imsk    <= 1'b0;
            dly_val <= '0;
        end else if (wr_en) begin
            if (addr == OFS_IMSK) imsk    <= wdata[0];
            if (addr == OFS_DLY)  dly_val <= wdata[DLY_W-1:0];
        end
    end

    // Raw completion flag: set by the sequencer, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)        raw <= 1'b0;
        else if (cmd_done) raw <= 1'b1;
        else if (clr_hit)  raw <= 1'b0;
    end

    // Read data multiplexer; status is inverted (1 = powered down).
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_STAT: rdata[N_DOM-1:0] = ~dom_on;
            OFS_IMSK: rdata[0]         = imsk;
            OFS_RAW:  rdata[0]         = raw;
            OFS_DLY:  rdata[DLY_W-1:0] = dly_val;
            default:  rdata            = '0;
        endcase
    end

    assign irq = raw & imsk;

    // R7: completion always reaches the raw flag
    a_r7_raw_set: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> raw);
    // R8: a write-one clear without a new completion drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !cmd_done) |=> !raw);
endmodule

// File: rtl/pwr_seq_ctrl.sv
// Top of the power domain sequencing controller: register port, domain
// sequencer and switch-delay timer. Assumes N_DOM between 1 and 8 and
// DLY_W below DATA_W.
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int N_DOM  = 4,
    parameter int DLY_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              legacy_mode,
    output logic [N_DOM-1:0]  dom_pwr_en,
    input  logic [N_DOM-1:0]  dom_pwr_ack,
    output logic              irq
);
    logic             up_wr, dn_wr, cmd_done, tmr_load, tmr_exp;
    logic [N_DOM-1:0] wmask, dom_on;
    logic [DLY_W-1:0] dly_val;

    pwr_seq_regs #(.N_DOM(N_DOM), .DLY_W(DLY_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .dom_on(dom_on), .cmd_done(cmd_done),
        .up_wr(up_wr), .dn_wr(dn_wr), .wmask(wmask), .dly_val(dly_val),
        .rdata(reg_rdata), .irq(irq)
    );

    pwr_seq_engine #(.N_DOM(N_DOM)) u_engine (
        .clk(clk), .rst_n(rst_n), .up_wr(up_wr), .dn_wr(dn_wr),
        .wmask(wmask), .legacy(legacy_mode), .dom_ack(dom_pwr_ack),
        .tmr_exp(tmr_exp), .tmr_load(tmr_load), .dom_en(dom_pwr_en),
        .dom_on(dom_on), .cmd_done(cmd_done)
    );

    pwr_seq_timer #(.CNT_W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(dly_val),
        .expired(tmr_exp)
    );
endmodule

// File: tb/test_pwr_seq_ctrl.sv
// Scoreboard bench: the driver pushes the expected enable edges
// ({direction, index}) into a queue; the monitor pops and compares them
// as they appear on dom_pwr_en. Register results are checked by the driver.
module test_pwr_seq_ctrl;
    localparam int N = 4;
    localparam logic [4:0] A_UP = 5'h00, A_DN = 5'h04, A_ST = 5'h08,
                           A_IM = 5'h0C, A_RAW = 5'h10, A_CLR = 5'h18,
                           A_DLY = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        legacy_mode = 1'b0;
    logic [N-1:0] dom_pwr_en;
    logic [N-1:0] dom_pwr_ack = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int prev_cyc = 0;
    int last_gap = 0;
    logic [3:0] exp_q[$];
    logic [N-1:0] en_prev = '0;

    pwr_seq_ctrl #(.N_DOM(N)) i_pwr_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .legacy_mode(legacy_mode), .dom_pwr_en(dom_pwr_en),
        .dom_pwr_ack(dom_pwr_ack), .irq(irq)
    );

    always #10 clk = ~clk;

    // Domain model: acknowledge follows enable one cycle later.
    always @(posedge clk) begin
        dom_pwr_ack <= dom_pwr_en;
        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: every enable edge must match the next expected item (R5).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (dom_pwr_en[i] != en_prev[i]) begin
                    last_gap = cyc - prev_cyc;
                    prev_cyc = cyc;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5/R10 unexpected enable edge", {dom_pwr_en[i], 3'(i)}, 0);
                    end else begin
                        logic [3:0] e;
                        e = exp_q.pop_front();
                        chk(e == {dom_pwr_en[i], 3'(i)}, "R5 enable edge order",
                            {dom_pwr_en[i], 3'(i)}, e);
                    end
                end
            end
        end
        en_prev = dom_pwr_en;
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push(input bit up, input int idx);
        exp_q.push_back({up, 3'(idx)});
    endtask

    task automatic wait_flag(output bit got);
        logic [31:0] d;
        got = 1'b0;
        for (int k = 0; k < 200; k++) begin
            rd(A_RAW, d);
            if (d[0]) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic expect_status(input string tag, input int exp);
        logic [31:0] d;
        rd(A_ST, d);
        chk(d == 32'(exp), tag, d, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        logic [31:0] d;
        bit got;
        int g1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_status("R1 status after reset", 32'hF);
        rd(A_IM, d);  chk(d == 0, "R1 mask after reset", d, 0);
        rd(A_RAW, d); chk(d == 0, "R1 raw after reset", d, 0);
        rd(A_DLY, d); chk(d == 0, "R1 delay after reset", d, 0);
        chk(irq == 0 && dom_pwr_en == 0, "R1 irq/enables low", {irq, dom_pwr_en}, 0);

        // R2, R7: power up domains 0 and 2 with the mask off
        wr(A_DLY, 3);
        push(1, 0); push(1, 2);
        wr(A_UP, 32'h5);
        wait_flag(got);
        chk(got, "R7 flag after power-up", got, 1);
        expect_status("R2 status after up 0x5", 32'hA);
        chk(irq == 0, "R9 irq masked", irq, 0);

        // R8: clear with 0 keeps, clear with 1 drops
        wr(A_CLR, 0);
        rd(A_RAW, d); chk(d == 1, "R8 clear with zero", d, 1);
        wr(A_CLR, 1);
        rd(A_RAW, d); chk(d == 0, "R8 clear with one", d, 0);

        // R4, R9: only domain 1 switches; irq with mask on
        wr(A_IM, 1);
        push(1, 1);
        wr(A_UP, 32'h7);
        wait_flag(got);
        expect_status("R4 already-on bits ignored", 32'h8);
        chk(irq == 1, "R9 irq raised with mask", irq, 1);
        wr(A_CLR, 1);
        #1; chk(irq == 0, "R9 irq after clear", irq, 0);

        // R4: bits above N_DOM only -> empty command, immediate completion
        wr(A_UP, 32'hF0);
        wait_flag(got);
        chk(got, "R4 empty command completes", got, 1);
        expect_status("R4 high bits ignored", 32'h8);
        wr(A_CLR, 1);

        // R3, R6: power down two domains, measure spacing
        push(0, 0); push(0, 1);
        wr(A_DN, 32'h3);
        wait_flag(got);
        chk(got, "R3 flag after power-down", got, 1);
        expect_status("R3 status after down 0x3", 32'hB);
        g1 = last_gap;
        chk(g1 == 7, "R6 step spacing delay 3", g1, 7);
        wr(A_CLR, 1);
        wr(A_DLY, 12);
        push(1, 0); push(1, 1);
        wr(A_UP, 32'h3);
        wait_flag(got);
        chk(last_gap - g1 == 9, "R6 spacing follows delay", last_gap - g1, 9);
        wr(A_CLR, 1);

        // R10: a command during a busy one is ignored
        wr(A_DLY, 20);
        push(1, 3);
        wr(A_UP, 32'h8);
        wr(A_DN, 32'h1);
        wait_flag(got);
        expect_status("R10 busy write ignored", 32'h0);
        wr(A_CLR, 1);

        // R11: legacy power-down to all-off raises no flag
        wr(A_DLY, 2);
        legacy_mode = 1'b1;
        push(0, 0); push(0, 1); push(0, 2); push(0, 3);
        wr(A_DN, 32'hF);
        wait_flag(got);
        chk(!got, "R11 legacy all-off no flag", got, 0);
        expect_status("R11 all domains off", 32'hF);
        push(1, 0);
        wr(A_UP, 32'h1);
        wait_flag(got);
        chk(got, "R11 legacy power-up flags", got, 1);
        wr(A_CLR, 1);
        legacy_mode = 1'b0;
        push(0, 0);
        wr(A_DN, 32'h1);
        wait_flag(got);
        chk(got, "R11 newer mode all-off flags", got, 1);
        expect_status("R11 status back to all off", 32'hF);

        // R12: command and unmapped offsets read 0
        rd(A_UP, d);  chk(d == 0, "R12 command reg reads 0", d, 0);
        rd(5'h14, d); chk(d == 0, "R12 unmapped reads 0", d, 0);

        chk(exp_q.size() == 0, "R5 all expected edges seen", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule